// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It does this by fetching translation descriptors from memory, one word at a time. A walk starts at a context table entry, which is chosen by the configured table pointer and context number. From there it descends through up to three page-table levels. Each descriptor either points to the next table, ends the walk with a leaf entry, or stops it with a fault. The level at which a leaf is found sets the page size: 16 MB, 256 KB or 4 KB.

A finished walk reports the physical address, a page-size code and the leaf entry. A failed walk reports a fault code that packs the level reached and the kind of failure. The walker keeps each leaf's referenced and modified flags up to date. It stores the updated entry back to the descriptor address it was read from, and only then reports completion. When translation is switched off, no memory access happens. Addresses pass straight through, except that instruction fetches in boot mode are redirected into a boot ROM window.

Only one walk runs at a time. A request is taken only while `req_ready` is high. Memory reads and writes use a request/valid handshake: the walker holds `mem_req` and the address until `mem_valid` answers.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `done`, `fault` and `mem_req` are 0.
- R2: With `cfg_enable` low, a request that is not a boot-mode fetch completes with `done` on the cycle after acceptance. It returns `rsp_pa` equal to the zero-extended VA and `rsp_size` 0, and makes no memory access.
- R3: With `cfg_enable` low and `cfg_boot` high, an instruction fetch (`req_kind` 2) returns `cfg_prom_base` ORed with VA[18:0]. A load (`req_kind` 0) in boot mode still passes through unchanged.
- R4: The first read is at (`cfg_ctx_ptr` << 4) + (`cfg_ctx_num` << 2). Each deeper read is at (descriptor with bits [1:0] cleared) << 4, plus an index times 4. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3. A walk that ends at level n makes n+1 reads.
- R5: Descriptor bits [1:0] give the type: 0 invalid, 1 next-table pointer, 2 leaf, 3 reserved. A leaf at level 1, 2 or 3 gives `rsp_size` 2, 1 or 0 respectively. `rsp_pa` is (descriptor[31:8] << 12) plus the VA bits below the page size (24, 18 or 12 bits).
- R6: `rsp_fault_code` is (level << 8) | (kind << 2), with kind 1 for an invalid entry and kind 4 for a translation error. Reserved entries at any level, and a table pointer at level 3, give kind 4.
- R7: At the context level (level 0), an invalid entry gives code 0x004. A leaf or reserved entry there gives 0x010.
- R8: Bit 5 of a leaf is the referenced flag and bit 6 the modified flag. The walker writes the leaf back to its own address before `done` when either of two conditions holds: bit 5 is clear, or the access is a store (`req_kind` 1) and bit 6 is clear. The written entry has bit 5 set, and also bit 6 for a store. `rsp_pte` carries the updated entry. Otherwise no write is made and `rsp_pte` is the entry as read.
- R9: `done` and `fault` are never high together, and each lasts exactly one cycle. `req_ready` is low from acceptance through the response cycle.
- R10: Once raised, `mem_req` holds with a stable address and direction until `mem_valid`. Every descriptor address is word aligned, and no memory request is made while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 load, 1 store, 2 instruction fetch |
| cfg_enable | input | 1 | Translation enabled |
| cfg_boot | input | 1 | Boot mode, fetches go to boot ROM when disabled |
| cfg_ctx_ptr | input | 32 | Context table pointer (physical address >> 4) |
| cfg_ctx_num | input | CTX_W | Context number |
| cfg_prom_base | input | 36 | Boot ROM base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 36 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_valid | input | 1 | Access completed (read data valid) |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Translation completed (one cycle) |
| fault | output | 1 | Translation failed (one cycle) |
| rsp_pa | output | 36 | Physical address |
| rsp_size | output | 2 | Page size: 0 4 KB, 1 256 KB, 2 16 MB |
| rsp_pte | output | 32 | Final leaf entry |
| rsp_fault_code | output | 10 | Level and failure kind |

## Verification
Two situations are hard to reach from the ports. The first is a write-back that is triggered only by the modified flag, which needs a leaf whose referenced flag is already set but whose modified flag is clear. The bench gets there by ordering its vectors: a load first sets the referenced flag through the walker's own write-back, and a store to the same page then forces the second write. The second is the set of faults that occur before any page-table level is reached. These are reached by switching the context number so that the first read lands on invalid, leaf and reserved context entries placed in the bench's memory model.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int VA_W   = 32;
    localparam int DESC_W = 32;
    localparam int PA_W   = 36;
    localparam int CTP_W  = PA_W - 4;
    localparam int FC_W   = 10;
    localparam int PPN_LSB = 8;
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;
    localparam int PG_SHIFT = 12;
    localparam logic [1:0] LVL_CTX  = 2'd0;
    localparam logic [1:0] LVL_LAST = 2'd3;

    typedef enum logic [1:0] {
        DT_INVALID = 2'd0,
        DT_TABLE   = 2'd1,
        DT_LEAF    = 2'd2,
        DT_RSVD    = 2'd3
    } dtype_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_OTHER = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_256K = 2'd1,
        PG_16M  = 2'd2,
        PG_NONE = 2'd3
    } pgsz_e;

    typedef enum logic [2:0] {
        FT_INVALID = 3'd1,
        FT_XLATE   = 3'd4
    } ftype_e;

    typedef enum logic [1:0] {
        ACT_DESCEND,
        ACT_LEAF,
        ACT_FAULT
    } act_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_DONE,
        S_FAULT
    } state_e;

    typedef struct packed {
        logic [PA_W-1:0]   pa;
        pgsz_e             size;
        logic [DESC_W-1:0] pte;
        logic [FC_W-1:0]   fc;
    } resp_t;

    function automatic logic [FC_W-1:0] mk_fault(input logic [1:0] lvl, input ftype_e kind);
        return {lvl, 3'b000, kind, 2'b00};
    endfunction

    function automatic pgsz_e leaf_size(input logic [1:0] lvl);
        case (lvl)
            2'd1:    return PG_16M;
            2'd2:    return PG_256K;
            default: return PG_4K;
        endcase
    endfunction

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
    import pt_walker_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [1:0]        level,
    input  logic [CTP_W-1:0]  ctx_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    input  logic [DESC_W-3:0] link,
    input  logic [VA_W-1:PG_SHIFT] va_hi,
    output logic [PA_W-1:0]   addr
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] index;

    always_comb begin
        base  = {link, 2'b00, 4'b0000};
        index = '0;
        unique case (level)
            2'd0: begin
                base  = {ctx_ptr, 4'b0000};
                index = PA_W'(ctx_num);
            end
            2'd1:    index = PA_W'(va_hi[31:24]);
            2'd2:    index = PA_W'(va_hi[23:18]);
            default: index = PA_W'(va_hi[17:12]);
        endcase
        addr = base + (index << 2);
    end
endmodule

// File: rtl/pt_desc_decode.sv
module pt_desc_decode
    import pt_walker_pkg::*;
(
    input  logic [1:0]      level,
    input  dtype_e          dtype,
    output act_e            act,
    output logic [FC_W-1:0] fc,
    output pgsz_e           size
);
    always_comb begin
        act  = ACT_FAULT;
        fc   = '0;
        size = PG_4K;
        unique case (dtype)
            DT_INVALID: fc = mk_fault(level, FT_INVALID);
            DT_RSVD:    fc = mk_fault(level, FT_XLATE);
            DT_TABLE: begin
                if (level == LVL_LAST) fc = mk_fault(level, FT_XLATE);
                else                   act = ACT_DESCEND;
            end
            default: begin
                if (level == LVL_CTX) begin
                    fc = mk_fault(level, FT_XLATE);
                end else begin
                    act  = ACT_LEAF;
                    size = leaf_size(level);
                end
            end
        endcase
    end
endmodule

// File: rtl/pt_leaf_update.sv
module pt_leaf_update
    import pt_walker_pkg::*;
(
    input  logic [DESC_W-1:0] entry,
    input  pgsz_e             size,
    input  logic [23:0]       va_lo,
    input  logic              is_store,
    output logic [PA_W-1:0]   pa,
    output logic [DESC_W-1:0] entry_new,
    output logic              need_wb
);
    logic [23:0] offset;

    always_comb begin
        unique case (size)
            PG_16M:  offset = va_lo;
            PG_256K: offset = {6'b0, va_lo[17:0]};
            default: offset = {12'b0, va_lo[11:0]};
        endcase
        pa = {entry[DESC_W-1:PPN_LSB], {PG_SHIFT{1'b0}}} + PA_W'(offset);

        entry_new = entry;
        entry_new[REF_BIT] = 1'b1;
        if (is_store) entry_new[MOD_BIT] = 1'b1;
        need_wb = !entry[REF_BIT] || (is_store && !entry[MOD_BIT]);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int CTX_W      = 8,
    parameter int BOOT_OFS_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_kind,
    input  logic              cfg_enable,
    input  logic              cfg_boot,
    input  logic [CTP_W-1:0]  cfg_ctx_ptr,
    input  logic [CTX_W-1:0]  cfg_ctx_num,
    input  logic [PA_W-1:0]   cfg_prom_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DESC_W-1:0] mem_wdata,
    input  logic              mem_valid,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_size,
    output logic [DESC_W-1:0] rsp_pte,
    output logic [FC_W-1:0]   rsp_fault_code
);
    state_e            state_q;
    logic [1:0]        level_q;
    logic [VA_W-1:0]   va_q;
    acc_e              kind_q;
    logic [PA_W-1:0]   addr_q;
    resp_t             rsp_q;

    logic [1:0]        gen_lvl;
    logic [VA_W-1:0]   gen_va;
    logic [PA_W-1:0]   gen_addr;
    logic [PA_W-1:0]   boot_pa;
    act_e              dec_act;
    logic [FC_W-1:0]   dec_fc;
    pgsz_e             dec_size;
    logic [PA_W-1:0]   leaf_pa;
    logic [DESC_W-1:0] leaf_new;
    logic              leaf_wb;

    // Address of the first descriptor on accept, of the next one while walking.
    always_comb begin
        if (state_q == S_IDLE) begin
            gen_lvl = LVL_CTX;
            gen_va  = req_va;
        end else begin
            gen_lvl = level_q + 2'd1;
            gen_va  = va_q;
        end
    end

    pt_addr_gen #(.CTX_W(CTX_W)) addr_gen_i (
        .level   (gen_lvl),
        .ctx_ptr (cfg_ctx_ptr),
        .ctx_num (cfg_ctx_num),
        .link    (mem_rdata[DESC_W-1:2]),
        .va_hi   (gen_va[VA_W-1:PG_SHIFT]),
        .addr    (gen_addr)
    );

    pt_desc_decode decode_i (
        .level (level_q),
        .dtype (dtype_e'(mem_rdata[1:0])),
        .act   (dec_act),
        .fc    (dec_fc),
        .size  (dec_size)
    );

    pt_leaf_update leaf_i (
        .entry     (mem_rdata),
        .size      (dec_size),
        .va_lo     (va_q[23:0]),
        .is_store  (kind_q == ACC_STORE),
        .pa        (leaf_pa),
        .entry_new (leaf_new),
        .need_wb   (leaf_wb)
    );

    assign boot_pa = cfg_prom_base | PA_W'(req_va[BOOT_OFS_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            level_q <= LVL_CTX;
            va_q    <= '0;
            kind_q  <= ACC_LOAD;
            addr_q  <= '0;
            rsp_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_va;
                        kind_q  <= acc_e'(req_kind);
                        level_q <= LVL_CTX;
                        addr_q  <= gen_addr;
                        rsp_q   <= '0;
                        if (!cfg_enable) begin
                            rsp_q.pa   <= (cfg_boot && acc_e'(req_kind) == ACC_FETCH)
                                          ? boot_pa : PA_W'(req_va);
                            rsp_q.size <= PG_4K;
                            state_q    <= S_DONE;
                        end else begin
                            state_q <= S_READ;
                        end
                    end
                end
                S_READ: begin
                    if (mem_valid) begin
                        unique case (dec_act)
                            ACT_DESCEND: begin
                                addr_q  <= gen_addr;
                                level_q <= level_q + 2'd1;
                            end
                            ACT_LEAF: begin
                                rsp_q.pa   <= leaf_pa;
                                rsp_q.size <= dec_size;
                                rsp_q.pte  <= leaf_wb ? leaf_new : mem_rdata;
                                state_q    <= leaf_wb ? S_WRITE : S_DONE;
                            end
                            default: begin
                                rsp_q.fc <= dec_fc;
                                state_q  <= S_FAULT;
                            end
                        endcase
                    end
                end
                S_WRITE: begin
                    if (mem_valid) state_q <= S_DONE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready      = (state_q == S_IDLE);
    assign mem_req        = (state_q == S_READ) || (state_q == S_WRITE);
    assign mem_we         = (state_q == S_WRITE);
    assign mem_addr       = addr_q;
    assign mem_wdata      = rsp_q.pte;
    assign done           = (state_q == S_DONE);
    assign fault          = (state_q == S_FAULT);
    assign rsp_pa         = rsp_q.pa;
    assign rsp_size       = rsp_q.size;
    assign rsp_pte        = rsp_q.pte;
    assign rsp_fault_code = rsp_q.fc;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [PA_W-1:0]   mem_addr,
    input logic [DESC_W-1:0] mem_wdata,
    input logic              mem_valid,
    input logic              done,
    input logic              fault,
    input logic [1:0]        rsp_size,
    input logic [FC_W-1:0]   rsp_fault_code
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(done && fault)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault); // R9
    AST_BUSY_IN_RESP: assert property (@(posedge clk) disable iff (rst)
        (done || fault) |-> !req_ready); // R9
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req); // R10
    AST_WB_REF_SET: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_wdata[REF_BIT]); // R8
    AST_FC_FORMAT: assert property (@(posedge clk) disable iff (rst)
        fault |-> (rsp_fault_code[1:0] == 2'b00 && rsp_fault_code[7:5] == 3'b000 &&
                   (rsp_fault_code[4:2] == 3'd1 || rsp_fault_code[4:2] == 3'd4))); // R6
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (rsp_size != 2'd3)); // R5
endmodule

bind pt_walker pt_walker_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .req_ready      (req_ready),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_valid      (mem_valid),
    .done           (done),
    .fault          (fault),
    .rsp_size       (rsp_size),
    .rsp_fault_code (rsp_fault_code)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;
    localparam int NVEC       = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        cfg_enable = 1'b1;
    logic        cfg_boot = 1'b0;
    logic [31:0] cfg_ctx_ptr = 32'h0000_1000;
    logic [7:0]  cfg_ctx_num = 8'd3;
    logic [35:0] cfg_prom_base = 36'hF_F000_0000;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_valid;
    logic [31:0] mem_rdata;
    logic        done, fault;
    logic [35:0] rsp_pa;
    logic [1:0]  rsp_size;
    logic [31:0] rsp_pte;
    logic [9:0]  rsp_fault_code;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int cyc = 0;
    logic [31:0] mem [logic [35:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_kind(req_kind), .cfg_enable(cfg_enable),
        .cfg_boot(cfg_boot), .cfg_ctx_ptr(cfg_ctx_ptr), .cfg_ctx_num(cfg_ctx_num),
        .cfg_prom_base(cfg_prom_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault), .rsp_pa(rsp_pa),
        .rsp_size(rsp_size), .rsp_pte(rsp_pte), .rsp_fault_code(rsp_fault_code)
    );

    // Memory model: one access per request, answered one cycle later.
    always @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_rdata <= '0;
            mem.delete();
            mem[36'h1000C] = 32'h0000_2001;
            mem[36'h10000] = 32'h0000_0000;
            mem[36'h10004] = 32'h0000_0002;
            mem[36'h10008] = 32'h0000_0003;
            mem[36'h20004] = 32'h3010_0062;
            mem[36'h20008] = 32'h0000_3001;
            mem[36'h20010] = 32'h0000_0003;
            mem[36'h30004] = 32'h0400_0002;
            mem[36'h30008] = 32'h0000_4001;
            mem[36'h30010] = 32'h0000_0003;
            mem[36'h40014] = 32'h0123_4522;
            mem[36'h4001C] = 32'h0000_0001;
            mem[36'h40020] = 32'h0000_0003;
        end else if (mem_valid) begin
            mem_valid <= 1'b0;
        end else if (mem_req) begin
            mem_valid <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                rd_cnt++;
            end
        end
    end

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic        flt;
        logic [9:0]  fc;
        logic [35:0] pa;
        logic [1:0]  size;
        logic [31:0] pte;
        logic        wr;
        logic [2:0]  nrd;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h0123_4567, 2'd0, 1'b0, 10'h000, 36'h3_0123_4567, 2'd2, 32'h3010_0062, 1'b0, 3'd2},
        '{32'h0123_4567, 2'd1, 1'b0, 10'h000, 36'h3_0123_4567, 2'd2, 32'h3010_0062, 1'b0, 3'd2},
        '{32'h0204_1234, 2'd0, 1'b0, 10'h000, 36'h0_4000_1234, 2'd1, 32'h0400_0022, 1'b1, 3'd3},
        '{32'h0204_1234, 2'd1, 1'b0, 10'h000, 36'h0_4000_1234, 2'd1, 32'h0400_0062, 1'b1, 3'd3},
        '{32'h0208_5ABC, 2'd1, 1'b0, 10'h000, 36'h0_1234_5ABC, 2'd0, 32'h0123_4562, 1'b1, 3'd4},
        '{32'h0208_5ABC, 2'd0, 1'b0, 10'h000, 36'h0_1234_5ABC, 2'd0, 32'h0123_4562, 1'b0, 3'd4},
        '{32'h0208_5000, 2'd2, 1'b0, 10'h000, 36'h0_1234_5000, 2'd0, 32'h0123_4562, 1'b0, 3'd4},
        '{32'h0208_6000, 2'd0, 1'b1, 10'h304, 36'h0,           2'd0, 32'h0,         1'b0, 3'd4},
        '{32'h0208_7000, 2'd0, 1'b1, 10'h310, 36'h0,           2'd0, 32'h0,         1'b0, 3'd4},
        '{32'h0208_8000, 2'd0, 1'b1, 10'h310, 36'h0,           2'd0, 32'h0,         1'b0, 3'd4},
        '{32'h020C_0000, 2'd0, 1'b1, 10'h204, 36'h0,           2'd0, 32'h0,         1'b0, 3'd3},
        '{32'h0210_0000, 2'd0, 1'b1, 10'h210, 36'h0,           2'd0, 32'h0,         1'b0, 3'd3},
        '{32'h0300_0000, 2'd0, 1'b1, 10'h104, 36'h0,           2'd0, 32'h0,         1'b0, 3'd2},
        '{32'h0400_0000, 2'd0, 1'b1, 10'h110, 36'h0,           2'd0, 32'h0,         1'b0, 3'd2}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one request; returns at the negedge where done or fault is high.
    task automatic walk(input logic [31:0] va, input logic [1:0] kind, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_va    = va;
        req_kind  = kind;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!(done || fault)) begin
            @(negedge clk);
            lat++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lat, rd0, wr0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "req_ready", 64'(req_ready), 64'd1);
        check("R1", "done", 64'(done), 64'd0);
        check("R1", "fault", 64'(fault), 64'd0);
        check("R1", "mem_req", 64'(mem_req), 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            rd0 = rd_cnt;
            wr0 = wr_cnt;
            walk(VECS[i].va, VECS[i].kind, lat);
            check("R9", "busy in response", 64'(req_ready), 64'd0);
            check("R4", "read count", 64'(rd_cnt - rd0), 64'(VECS[i].nrd));
            if (VECS[i].flt) begin
                check("R6", "fault", 64'(fault), 64'd1);
                check("R6", "fault code", 64'(rsp_fault_code), 64'(VECS[i].fc));
            end else begin
                check("R5", "done", 64'(done), 64'd1);
                check("R5", "pa", 64'(rsp_pa), 64'(VECS[i].pa));
                check("R5", "size", 64'(rsp_size), 64'(VECS[i].size));
                check("R8", "pte", 64'(rsp_pte), 64'(VECS[i].pte));
            end
            check("R8", "write count", 64'(wr_cnt - wr0), 64'(VECS[i].wr));
            @(negedge clk);
            check("R9", "single-cycle response", 64'(done | fault), 64'd0);
        end

        // Written-back entries now sit in memory.
        check("R8", "stored 256K entry", 64'(mem[36'h30004]), 64'h0400_0062);
        check("R8", "stored 4K entry", 64'(mem[36'h40014]), 64'h0123_4562);

        // Context-level outcomes.
        cfg_ctx_num = 8'd0;
        walk(32'h0100_0000, 2'd0, lat);
        check("R7", "ctx invalid", 64'({fault, rsp_fault_code}), 64'({1'b1, 10'h004}));
        @(negedge clk);
        cfg_ctx_num = 8'd1;
        walk(32'h0100_0000, 2'd0, lat);
        check("R7", "ctx leaf", 64'({fault, rsp_fault_code}), 64'({1'b1, 10'h010}));
        @(negedge clk);
        cfg_ctx_num = 8'd2;
        walk(32'h0100_0000, 2'd0, lat);
        check("R7", "ctx reserved", 64'({fault, rsp_fault_code}), 64'({1'b1, 10'h010}));
        @(negedge clk);
        cfg_ctx_num = 8'd3;

        // Translation disabled.
        cfg_enable = 1'b0;
        rd0 = rd_cnt;
        walk(32'hDEAD_BEEF, 2'd0, lat);
        check("R2", "bypass done", 64'(done), 64'd1);
        check("R2", "bypass latency", 64'(lat), 64'd1);
        check("R2", "bypass pa", 64'(rsp_pa), 64'h0_DEAD_BEEF);
        check("R2", "bypass size", 64'(rsp_size), 64'd0);
        check("R2", "bypass no reads", 64'(rd_cnt - rd0), 64'd0);
        cfg_boot = 1'b1;
        walk(32'hFFF8_1234, 2'd2, lat);
        check("R3", "boot fetch pa", 64'(rsp_pa), 64'hF_F000_1234);
        walk(32'hFFF8_1234, 2'd0, lat);
        check("R3", "boot load pa", 64'(rsp_pa), 64'h0_FFF8_1234);
        cfg_boot = 1'b0;
        walk(32'hFFF8_1234, 2'd2, lat);
        check("R2", "non-boot fetch pa", 64'(rsp_pa), 64'h0_FFF8_1234);
        cfg_enable = 1'b1;

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule